// File: doc/BRIEF.md
# Shaded Vertex Reuse Assembly Cache

This block assembles triangles for a setup stage from fully shaded vertices. It holds four shaded vertices, each tagged by its vertex index. For every triangle it receives, it checks which of the three corners are already held. It requests only the missing ones from the larger shaded-vertex store upstream, and it releases the triangle downstream once all three corners are present. Corners that are already held cost no upstream traffic at all.

Triangles come in either as independent lists or as strips. In strip mode a triangle that follows another one takes its first two corners from the last two corners of the previous triangle, and only the third index on the input is new. A restart pulse drops that history, so the next strip triangle takes all three indices from the input again. Cache contents survive a restart. Missing corners are fetched one at a time over a request/response pair. Each response carries the index it answers, so it can be matched to the outstanding request.

Top module: `vtx_asm_cache`

## Requirements
- R1: After reset the block shows inReady=1, outValid=0 and fetchReqValid=0, and the cache is empty, so a first triangle of three distinct indices fetches all three.
- R2: A triangle whose three corners are all resident is accepted without any fetch request, and outValid is high in the cycle after the acceptance edge.
- R3: Missing corners are requested in corner order 0, 1, 2, one at a time. fetchReqValid and fetchReqIdx hold steady until fetchReqReady. After a request handshake no new request appears until the matching response has arrived.
- R4: A response whose fetchRspIdx differs from the outstanding request is ignored. The request stays outstanding, no new request is raised and no triangle is released.
- R5: An index that appears more than once in one triangle is fetched at most once.
- R6: outValid rises only when all three corners are present. outIdx0..2 give the corners in the triangle's own order. Each outDataK is the payload the store returned for outIdxK. Both stay stable while outValid is high and outReady is low.
- R7: inReady is high only while no triangle is being assembled or presented, so at most one of inReady, fetchReqValid and outValid is high. After an output handshake inReady is high again in the next cycle.
- R8: In strip mode with live history, the triangle is (corner 1 of the previous accepted triangle, corner 2 of the previous accepted triangle, inIdx2), and inIdx0 and inIdx1 are ignored. History is recorded for every accepted triangle, whatever its mode.
- R9: A stripRestart pulse clears the history, and so does reset. A strip triangle accepted with no history, or in the same cycle as stripRestart, uses inIdx0, inIdx1 and inIdx2.
- R10: A strip triangle whose two reused corners are resident issues exactly one fetch when its new index misses, and none when it hits.
- R11: A fill goes to an empty entry when one exists. Otherwise it replaces the least recently used entry that does not hold a corner of the triangle being assembled. Recency is updated at the output handshake in corner order 0, 1, 2, so corner 2 ends up most recent.
- R12: stripRestart leaves the cached vertices intact, so resident indices still hit after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Triangle offered on the input |
| inReady | output | 1 | Block can accept a triangle |
| stripMode | input | 1 | 1: strip triangle, 0: list triangle |
| stripRestart | input | 1 | Clears the strip history |
| inIdx0 | input | IDX_W | Corner 0 index (list, or strip without history) |
| inIdx1 | input | IDX_W | Corner 1 index (list, or strip without history) |
| inIdx2 | input | IDX_W | Corner 2 index, new vertex in strip mode |
| fetchReqValid | output | 1 | Upstream fetch request valid |
| fetchReqReady | input | 1 | Upstream takes the request |
| fetchReqIdx | output | IDX_W | Index of the requested vertex |
| fetchRspValid | input | 1 | Upstream response valid |
| fetchRspIdx | input | IDX_W | Index the response belongs to |
| fetchRspData | input | DATA_W | Shaded vertex payload |
| outValid | output | 1 | Assembled triangle valid |
| outReady | input | 1 | Setup stage takes the triangle |
| outIdx0 | output | IDX_W | Corner 0 index |
| outIdx1 | output | IDX_W | Corner 1 index |
| outIdx2 | output | IDX_W | Corner 2 index |
| outData0 | output | DATA_W | Corner 0 payload |
| outData1 | output | DATA_W | Corner 1 payload |
| outData2 | output | DATA_W | Corner 2 payload |

## Verification
A stale or wrong tag shows up within the same triangle, either as a missing fetch request with a wrong payload on outDataK, or as a request for a vertex that should have hit. A wrong recency order or a bad victim choice stays hidden until a later triangle, where it appears as an extra or missing fetch. The bench therefore compares the full request sequence of every triangle against a recency-list model across long mixed runs of strip and list triangles. Broken strip history shows on the very next strip triangle as wrong outIdx values.

// File: rtl/vac_pkg.sv
package vac_pkg;
  localparam int NUM_WAYS    = 4;
  localparam int WAY_W       = $clog2(NUM_WAYS);
  localparam int NUM_CORNERS = 3;
  localparam int CRN_W       = $clog2(NUM_CORNERS);

  typedef logic [WAY_W-1:0] way_t;

  // strobes from the sequencer to the vertex store
  typedef struct packed {
    logic fillEn;
    way_t fillWay;
    logic touchEn;
  } store_ctl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} asm_state_e;
endpackage

// File: rtl/vac_store.sv
module vac_store
  import vac_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  store_ctl_t                          ctl,
  input  logic [IDX_W-1:0]                    fillIdx,
  input  logic [DATA_W-1:0]                   fillData,
  input  logic [NUM_CORNERS-1:0][IDX_W-1:0]   qIdx,
  output logic [NUM_CORNERS-1:0]              qHit,
  output way_t [NUM_CORNERS-1:0]              qWay,
  input  logic [NUM_WAYS-1:0]                 pinMask,
  output way_t                                victimWay,
  input  way_t [NUM_CORNERS-1:0]              rdWay,
  output logic [NUM_CORNERS-1:0][DATA_W-1:0]  rdData
);
  logic [NUM_WAYS-1:0] entValid;
  logic [IDX_W-1:0]    entTag  [NUM_WAYS];
  logic [DATA_W-1:0]   entData [NUM_WAYS];
  way_t                entAge  [NUM_WAYS];
  way_t                ageNext [NUM_WAYS];

  // tag compare for each corner
  always_comb begin
    for (int c = 0; c < NUM_CORNERS; c++) begin
      qHit[c] = 1'b0;
      qWay[c] = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (entValid[w] && entTag[w] == qIdx[c]) begin
          qHit[c] = 1'b1;
          qWay[c] = way_t'(w);
        end
      end
    end
  end

  // victim: free entry first, else oldest entry not pinned by the triangle
  always_comb begin
    logic found;
    way_t bestAge;
    found     = 1'b0;
    bestAge   = '0;
    victimWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!found && !pinMask[w] && !entValid[w]) begin
        victimWay = way_t'(w);
        found     = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (!pinMask[w] && (!found || entAge[w] >= bestAge)) begin
          victimWay = way_t'(w);
          bestAge   = entAge[w];
          found     = 1'b1;
        end
      end
    end
  end

  // recency update, corners touched in order so corner 2 ends youngest
  always_comb begin
    way_t refAge;
    for (int w = 0; w < NUM_WAYS; w++) ageNext[w] = entAge[w];
    for (int c = 0; c < NUM_CORNERS; c++) begin
      refAge = ageNext[rdWay[c]];
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (ageNext[w] < refAge) ageNext[w] = ageNext[w] + 1'b1;
      end
      ageNext[rdWay[c]] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid <= '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        entTag[w]  <= '0;
        entData[w] <= '0;
        entAge[w]  <= way_t'(w);
      end
    end else begin
      if (ctl.fillEn) begin
        entValid[ctl.fillWay] <= 1'b1;
        entTag[ctl.fillWay]   <= fillIdx;
        entData[ctl.fillWay]  <= fillData;
      end
      if (ctl.touchEn) begin
        for (int w = 0; w < NUM_WAYS; w++) entAge[w] <= ageNext[w];
      end
    end
  end

  for (genvar c = 0; c < NUM_CORNERS; c++) begin : gRead
    assign rdData[c] = entData[rdWay[c]];
  end
endmodule

// File: rtl/vac_ctrl.sv
module vac_ctrl
  import vac_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               inValid,
  output logic                               inReady,
  input  logic                               stripMode,
  input  logic                               stripRestart,
  input  logic [NUM_CORNERS-1:0][IDX_W-1:0]  inIdx,
  output logic                               fetchReqValid,
  input  logic                               fetchReqReady,
  output logic [IDX_W-1:0]                   fetchReqIdx,
  input  logic                               fetchRspValid,
  input  logic [IDX_W-1:0]                   fetchRspIdx,
  output logic                               outValid,
  input  logic                               outReady,
  output logic [NUM_CORNERS-1:0][IDX_W-1:0]  outIdx,
  output logic [NUM_CORNERS-1:0][IDX_W-1:0]  qIdx,
  input  logic [NUM_CORNERS-1:0]             qHit,
  input  way_t [NUM_CORNERS-1:0]             qWay,
  input  way_t                               victimWay,
  output logic [NUM_WAYS-1:0]                pinMask,
  output way_t [NUM_CORNERS-1:0]             rdWay,
  output store_ctl_t                         ctl,
  output logic [IDX_W-1:0]                   fillIdx
);
  asm_state_e                        state;
  logic [NUM_CORNERS-1:0][IDX_W-1:0] slotIdx;
  logic [NUM_CORNERS-1:0]            slotHave;
  way_t [NUM_CORNERS-1:0]            slotWay;
  logic [1:0][IDX_W-1:0]             histIdx;
  logic                              histValid;
  logic                              useHist;
  logic [CRN_W-1:0]                  firstMiss;
  logic [IDX_W-1:0]                  pendIdx;
  logic                              rspMatch;
  logic [NUM_CORNERS-1:0]            haveNext;

  assign useHist = stripMode && histValid && !stripRestart;
  assign qIdx[0] = useHist ? histIdx[0] : inIdx[0];
  assign qIdx[1] = useHist ? histIdx[1] : inIdx[1];
  assign qIdx[2] = inIdx[2];

  always_comb begin
    firstMiss = '0;
    for (int c = NUM_CORNERS-1; c >= 0; c--) begin
      if (!slotHave[c]) firstMiss = CRN_W'(c);
    end
  end

  assign pendIdx  = slotIdx[firstMiss];
  assign rspMatch = (state == ST_WAIT) && fetchRspValid && (fetchRspIdx == pendIdx);

  always_comb begin
    pinMask = '0;
    for (int c = 0; c < NUM_CORNERS; c++) begin
      if (slotHave[c]) pinMask[slotWay[c]] = 1'b1;
      haveNext[c] = slotHave[c] || (slotIdx[c] == pendIdx);
    end
  end

  assign ctl.fillEn  = rspMatch;
  assign ctl.fillWay = victimWay;
  assign ctl.touchEn = (state == ST_OUT) && outReady;
  assign fillIdx     = pendIdx;

  assign inReady       = (state == ST_IDLE);
  assign fetchReqValid = (state == ST_REQ);
  assign fetchReqIdx   = pendIdx;
  assign outValid      = (state == ST_OUT);
  assign outIdx        = slotIdx;
  assign rdWay         = slotWay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slotIdx   <= '0;
      slotHave  <= '0;
      slotWay   <= '0;
      histIdx   <= '0;
      histValid <= 1'b0;
    end else begin
      if (stripRestart) histValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (inValid) begin
            slotIdx    <= qIdx;
            slotHave   <= qHit;
            slotWay    <= qWay;
            histIdx[0] <= qIdx[1];
            histIdx[1] <= qIdx[2];
            histValid  <= 1'b1;
            state      <= (&qHit) ? ST_OUT : ST_REQ;
          end
        end
        ST_REQ: begin
          if (fetchReqReady) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rspMatch) begin
            for (int c = 0; c < NUM_CORNERS; c++) begin
              if (!slotHave[c] && slotIdx[c] == pendIdx) begin
                slotHave[c] <= 1'b1;
                slotWay[c]  <= victimWay;
              end
            end
            state <= (&haveNext) ? ST_OUT : ST_REQ;
          end
        end
        ST_OUT: begin
          if (outReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtx_asm_cache.sv
module vtx_asm_cache
  import vac_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic              stripMode,
  input  logic              stripRestart,
  input  logic [IDX_W-1:0]  inIdx0,
  input  logic [IDX_W-1:0]  inIdx1,
  input  logic [IDX_W-1:0]  inIdx2,
  output logic              fetchReqValid,
  input  logic              fetchReqReady,
  output logic [IDX_W-1:0]  fetchReqIdx,
  input  logic              fetchRspValid,
  input  logic [IDX_W-1:0]  fetchRspIdx,
  input  logic [DATA_W-1:0] fetchRspData,
  output logic              outValid,
  input  logic              outReady,
  output logic [IDX_W-1:0]  outIdx0,
  output logic [IDX_W-1:0]  outIdx1,
  output logic [IDX_W-1:0]  outIdx2,
  output logic [DATA_W-1:0] outData0,
  output logic [DATA_W-1:0] outData1,
  output logic [DATA_W-1:0] outData2
);
  logic [NUM_CORNERS-1:0][IDX_W-1:0]  inIdxBus;
  logic [NUM_CORNERS-1:0][IDX_W-1:0]  outIdxBus;
  logic [NUM_CORNERS-1:0][IDX_W-1:0]  qIdx;
  logic [NUM_CORNERS-1:0]             qHit;
  way_t [NUM_CORNERS-1:0]             qWay;
  way_t                               victimWay;
  logic [NUM_WAYS-1:0]                pinMask;
  way_t [NUM_CORNERS-1:0]             rdWay;
  logic [NUM_CORNERS-1:0][DATA_W-1:0] rdData;
  store_ctl_t                         ctl;
  logic [IDX_W-1:0]                   fillIdx;

  assign inIdxBus = {inIdx2, inIdx1, inIdx0};

  vac_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inReady(inReady),
    .stripMode(stripMode), .stripRestart(stripRestart), .inIdx(inIdxBus),
    .fetchReqValid(fetchReqValid), .fetchReqReady(fetchReqReady), .fetchReqIdx(fetchReqIdx),
    .fetchRspValid(fetchRspValid), .fetchRspIdx(fetchRspIdx),
    .outValid(outValid), .outReady(outReady), .outIdx(outIdxBus),
    .qIdx(qIdx), .qHit(qHit), .qWay(qWay), .victimWay(victimWay),
    .pinMask(pinMask), .rdWay(rdWay), .ctl(ctl), .fillIdx(fillIdx)
  );

  vac_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) uStore (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .fillIdx(fillIdx), .fillData(fetchRspData),
    .qIdx(qIdx), .qHit(qHit), .qWay(qWay),
    .pinMask(pinMask), .victimWay(victimWay),
    .rdWay(rdWay), .rdData(rdData)
  );

  assign outIdx0  = outIdxBus[0];
  assign outIdx1  = outIdxBus[1];
  assign outIdx2  = outIdxBus[2];
  assign outData0 = rdData[0];
  assign outData1 = rdData[1];
  assign outData2 = rdData[2];
endmodule

// File: rtl/vac_checker.sv
module vac_checker #(
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inReady,
  input logic              fetchReqValid,
  input logic              fetchReqReady,
  input logic [IDX_W-1:0]  fetchReqIdx,
  input logic              outValid,
  input logic              outReady,
  input logic [IDX_W-1:0]  outIdx0,
  input logic [IDX_W-1:0]  outIdx1,
  input logic [IDX_W-1:0]  outIdx2,
  input logic [DATA_W-1:0] outData0,
  input logic [DATA_W-1:0] outData1,
  input logic [DATA_W-1:0] outData2
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outIdx0) && $stable(outIdx1) && $stable(outIdx2)
      && $stable(outData0) && $stable(outData1) && $stable(outData2)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReqValid && !fetchReqReady |=> fetchReqValid && $stable(fetchReqIdx)); // R3
  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReqValid && fetchReqReady |=> !fetchReqValid); // R3
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inReady, fetchReqValid, outValid})); // R7
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady |=> inReady); // R7
endmodule

bind vtx_asm_cache vac_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rst_n(rst_n), .inReady(inReady),
  .fetchReqValid(fetchReqValid), .fetchReqReady(fetchReqReady), .fetchReqIdx(fetchReqIdx),
  .outValid(outValid), .outReady(outReady),
  .outIdx0(outIdx0), .outIdx1(outIdx1), .outIdx2(outIdx2),
  .outData0(outData0), .outData1(outData1), .outData2(outData2)
);

// File: tb/vtx_asm_cache_test.sv
module vtx_asm_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic inValid, inReady, stripMode, stripRestart;
  logic [IW-1:0] inIdx0, inIdx1, inIdx2;
  logic fetchReqValid, fetchReqReady;
  logic [IW-1:0] fetchReqIdx;
  logic fetchRspValid;
  logic [IW-1:0] fetchRspIdx;
  logic [DW-1:0] fetchRspData;
  logic outValid, outReady;
  logic [IW-1:0] outIdx0, outIdx1, outIdx2;
  logic [DW-1:0] outData0, outData1, outData2;

  int checks = 0;
  int fails = 0;
  int fetchCnt = 0;
  logic [IW-1:0] fetchLog [8];

  // reference model state
  logic [IW-1:0] lruTag [4];
  int lruCnt = 0;
  logic [IW-1:0] mHist0, mHist1;
  bit mHist = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtx_asm_cache #(.IDX_W(IW), .DATA_W(DW)) uut (.*);

  function automatic logic [DW-1:0] vdata(input logic [IW-1:0] i);
    return {i ^ 16'hA5C3, i};
  endfunction

  task automatic doCheck(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit inList(input logic [IW-1:0] t);
    for (int k = 0; k < lruCnt; k++) if (lruTag[k] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic mTouch(input logic [IW-1:0] t);
    int p;
    p = 0;
    for (int k = 0; k < lruCnt; k++) if (lruTag[k] == t) p = k;
    for (int k = p; k > 0; k--) lruTag[k] = lruTag[k-1];
    lruTag[0] = t;
  endtask

  task automatic mFill(input logic [IW-1:0] t, input logic [IW-1:0] e0, e1, e2);
    if (lruCnt < 4) begin
      lruTag[lruCnt] = t;
      lruCnt++;
    end else begin
      int v;
      v = -1;
      for (int k = 3; k >= 0; k--)
        if (v < 0 && lruTag[k] != e0 && lruTag[k] != e1 && lruTag[k] != e2) v = k;
      for (int k = v; k < 3; k++) lruTag[k] = lruTag[k+1];
      lruTag[3] = t;
    end
  endtask

  // upstream store model: variable ready delay, optional stray response
  int rspTurn = 0;
  initial begin
    logic [IW-1:0] pend;
    fetchReqReady = 1'b0;
    fetchRspValid = 1'b0;
    fetchRspIdx   = '0;
    fetchRspData  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && fetchReqValid) begin
        pend = fetchReqIdx;
        for (int d = 0; d < rspTurn % 3; d++) begin
          @(negedge clk);
          doCheck(fetchReqValid && fetchReqIdx == pend, "R3 request hold", fetchReqIdx, pend);
        end
        fetchReqReady = 1'b1;
        if (fetchCnt < 8) fetchLog[fetchCnt] = pend;
        fetchCnt++;
        @(negedge clk);
        fetchReqReady = 1'b0;
        if (rspTurn % 4 == 1) begin
          fetchRspValid = 1'b1;
          fetchRspIdx   = pend + 16'd1;
          fetchRspData  = 32'hDEAD_BEEF;
          @(negedge clk);
          fetchRspValid = 1'b0;
          doCheck(!fetchReqValid && !outValid, "R4 stray response ignored",
                  {fetchReqValid, outValid}, 2'b00);
        end
        for (int d = 0; d < rspTurn % 2; d++) @(negedge clk);
        fetchRspValid = 1'b1;
        fetchRspIdx   = pend;
        fetchRspData  = vdata(pend);
        @(negedge clk);
        fetchRspValid = 1'b0;
        rspTurn++;
      end
    end
  end

  task automatic pulseRestart();
    stripRestart = 1'b1;
    @(negedge clk);
    stripRestart = 1'b0;
    mHist = 1'b0;
  endtask

  task automatic sendTri(input bit strip, input bit rst, input logic [IW-1:0] a, b, c,
                         input int holdOut, input string tag);
    logic [IW-1:0] e0, e1, e2;
    logic [IW-1:0] expF [3];
    int expN;
    expN = 0;
    if (strip && mHist && !rst) begin
      e0 = mHist0; e1 = mHist1; e2 = c;
    end else begin
      e0 = a; e1 = b; e2 = c;
    end
    mHist0 = e1; mHist1 = e2; mHist = 1'b1;
    for (int k = 0; k < 3; k++) begin
      logic [IW-1:0] t;
      t = (k == 0) ? e0 : (k == 1) ? e1 : e2;
      if (!inList(t)) begin
        expF[expN] = t;
        expN++;
        mFill(t, e0, e1, e2);
      end
    end
    mTouch(e0); mTouch(e1); mTouch(e2);

    fetchCnt = 0;
    doCheck(inReady, "R7 ready before triangle", inReady, 1);
    inValid = 1'b1; stripMode = strip; stripRestart = rst;
    inIdx0 = a; inIdx1 = b; inIdx2 = c;
    @(negedge clk);
    inValid = 1'b0; stripRestart = 1'b0;
    if (rst) mHist0 = e1;
    if (expN == 0)
      doCheck(outValid, {"R2 all-hit output next cycle ", tag}, outValid, 1);
    while (!outValid) @(negedge clk);
    for (int h = 0; h < holdOut; h++) begin
      doCheck(outValid && outIdx2 == e2, {"R6 hold ", tag}, outIdx2, e2);
      @(negedge clk);
    end
    doCheck(fetchCnt == expN, {"R3 R10 fetch count ", tag}, fetchCnt, expN);
    for (int k = 0; k < expN && k < fetchCnt; k++)
      doCheck(fetchLog[k] == expF[k], {"R3 R5 R11 fetch order ", tag}, fetchLog[k], expF[k]);
    doCheck({outIdx0, outIdx1, outIdx2} == {e0, e1, e2}, {"R6 R8 R9 corner order ", tag},
            {outIdx0, outIdx1, outIdx2}, {e0, e1, e2});
    doCheck({outData0, outData1} == {vdata(e0), vdata(e1)}, {"R6 payload 0-1 ", tag},
            {outData0, outData1}, {vdata(e0), vdata(e1)});
    doCheck(outData2 == vdata(e2), {"R6 payload 2 ", tag}, outData2, vdata(e2));
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    doCheck(inReady && !outValid, "R7 idle after release", {inReady, outValid}, 2'b10);
  endtask

  initial begin
    int unsigned seed;
    rst_n = 1'b0; inValid = 1'b0; stripMode = 1'b0; stripRestart = 1'b0;
    outReady = 1'b0; inIdx0 = '0; inIdx1 = '0; inIdx2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    doCheck(inReady && !outValid && !fetchReqValid, "R1 reset state",
            {inReady, outValid, fetchReqValid}, 3'b100);

    sendTri(0, 0, 16'd1, 16'd2, 16'd3, 0, "R1 cold");
    sendTri(0, 0, 16'd1, 16'd2, 16'd3, 1, "R2 warm");
    sendTri(0, 0, 16'd4, 16'd4, 16'd5, 0, "R5 repeat");
    sendTri(1, 0, 16'd99, 16'd98, 16'd6, 2, "R8 R10 strip one miss");
    sendTri(1, 0, 16'd77, 16'd77, 16'd5, 0, "R8 R10 strip all hit");
    pulseRestart();
    sendTri(1, 0, 16'd6, 16'd5, 16'd4, 0, "R9 R12 after restart");
    sendTri(1, 1, 16'd1, 16'd2, 16'd3, 0, "R9 restart with triangle");
    sendTri(0, 0, 16'd10, 16'd11, 16'd12, 0, "R11 evict");
    sendTri(0, 0, 16'd3, 16'd10, 16'd2, 0, "R11 recency");

    seed = 32'h1234_5678;
    for (int n = 0; n < 240; n++) begin
      logic [IW-1:0] a, b, c;
      seed = seed * 1103515245 + 12345; a = IW'((seed >> 16) % 8);
      seed = seed * 1103515245 + 12345; b = IW'((seed >> 16) % 8);
      seed = seed * 1103515245 + 12345; c = IW'((seed >> 16) % 8);
      if (n % 23 == 7) pulseRestart();
      sendTri(n % 5 != 0, n % 17 == 3, a, b, c, n % 3, "R11 sweep");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule